// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit I/O virtual address into a physical address by fetching two 32-bit table entries from memory, one after the other. The top 12 address bits select an entry in a directory whose base comes from an input register value. That directory entry points to a 1 KiB-aligned table of page entries. The next 8 bits select one of those page entries. The page entry gives a 4 KiB frame address and a 4-bit authority index. The low 12 bits of the input address pass through unchanged as the byte offset.

A client hands over one address at a time with a valid/ready handshake. The walker then reads memory through a request/acknowledge port that may stall for any number of cycles. It answers with a single-cycle response. If either entry is not marked valid, the walk ends with an error response. A sticky fault flag for that level is set, and the offending virtual address is kept in that level's error-address register until software clears the flag.

Top module: `tbl_walker`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid and mem_req are 0, both fault flags are 0 and both error addresses are 0.
- R2: The first memory read of a walk goes to {dir_base[31:14], iova[31:20], 2'b00}. The low 14 bits of dir_base are ignored.
- R3: The second read goes to {dte[31:10], iova[19:12], 2'b00}, where dte is the data returned by the first read.
- R4: A directory entry is valid only when its bits 1:0 equal 2'b01. Its bits 9:2 have no effect on the result.
- R5: A page entry is valid when its bit 1 is 1. Its bits 11:8, 3:2 and 0 have no effect on the result.
- R6: A successful walk responds with rsp_err=0, rsp_pa={pte[31:12], iova[11:0]} and rsp_aci=pte[7:4].
- R7: An invalid directory entry ends the walk after one read. The response has rsp_err=1 with rsp_pa and rsp_aci zero. flt_dir becomes 1 and flt_dir_addr takes the iova.
- R8: An invalid page entry ends the walk after two reads. The response has rsp_err=1 with rsp_pa and rsp_aci zero. flt_pg becomes 1 and flt_pg_addr takes the iova.
- R9: mem_req stays high with a stable mem_addr until mem_ack, however many wait cycles the memory inserts.
- R10: req_ready is 0 from the cycle after acceptance until the response. rsp_valid lasts exactly one cycle, after which req_ready is 1 again.
- R11: Writing 1 to fault_clr[0] clears flt_dir, and writing 1 to fault_clr[1] clears flt_pg. Each bit leaves the other level's flag untouched.
- R12: Error-address registers change only on a fault of their own level. Successful walks and flag clears leave them as they are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dir_base | input | 32 | Directory base address (bits 31:14 used) |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request accepted this cycle if valid |
| req_iova | input | 32 | Virtual address to translate |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_err | output | 1 | Walk ended on an invalid entry |
| rsp_pa | output | 32 | Physical address (zero on error) |
| rsp_aci | output | 4 | Authority index from the page entry (zero on error) |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Byte address of the entry to read |
| mem_ack | input | 1 | Read data returned this cycle |
| mem_rdata | input | 32 | Entry data, valid with mem_ack |
| fault_clr | input | 2 | Write-one-clear: bit 0 directory flag, bit 1 page flag |
| flt_dir | output | 1 | Sticky directory-level fault flag |
| flt_pg | output | 1 | Sticky page-level fault flag |
| flt_dir_addr | output | 32 | Virtual address of the last directory-level fault |
| flt_pg_addr | output | 32 | Virtual address of the last page-level fault |

## Verification
The assertions assume a memory that raises mem_ack only while mem_req is high, for a single cycle, with mem_rdata valid in that cycle. They also assume that fault_clr is not asserted in the same cycle that the matching fault is detected. The bench memory model meets this. It answers only a pending request, after a chosen number of wait cycles, and drops mem_ack on the next cycle. The bench pulses the clear bits only while the walker is idle. Entries the bench never wrote read back as zero. That makes unmapped directory slots the natural invalid-entry case.

// File: rtl/walk_pkg.sv
package walk_pkg;
   typedef enum logic [2:0] {
      W_IDLE  = 3'd0,
      W_DIR   = 3'd1,
      W_PG    = 3'd2,
      W_DONE  = 3'd3,
      W_FAULT = 3'd4
   } walk_state_e;

   localparam int LVL_DIR  = 0;
   localparam int LVL_PG   = 1;
   localparam int N_LEVELS = 2;
endpackage

// File: rtl/walk_entry_decode.sv
module walk_entry_decode #(
   parameter int ENTRY_W  = 32,
   parameter int PTR_LSB  = 10,
   parameter int ACI_LSB  = 4,
   parameter int ACI_W    = 4,
   parameter bit DIR_KIND = 1'b1
) (
   input  logic [ENTRY_W-1:0]         entry,
   output logic                       ok,
   output logic [ENTRY_W-PTR_LSB-1:0] ptr_hi,
   output logic [ACI_W-1:0]           aci
);
   if (PTR_LSB < 3 || PTR_LSB >= ENTRY_W) begin : g_bad_ptr
      $error("walk_entry_decode: PTR_LSB out of range");
   end
   if (!DIR_KIND && (ACI_LSB < 2 || ACI_LSB + ACI_W > PTR_LSB)) begin : g_bad_aci
      $error("walk_entry_decode: authority field overlaps other fields");
   end

   assign ptr_hi = entry[ENTRY_W-1:PTR_LSB];

   if (DIR_KIND) begin : g_dir
      logic unused_rsv;
      assign ok         = (entry[1:0] == 2'b01);
      assign aci        = '0;
      assign unused_rsv = ^entry[PTR_LSB-1:2];
   end else begin : g_pg
      logic unused_rsv;
      assign ok         = entry[1];
      assign aci        = entry[ACI_LSB +: ACI_W];
      assign unused_rsv = ^{entry[PTR_LSB-1:ACI_LSB+ACI_W], entry[ACI_LSB-1:2], entry[0]};
   end
endmodule

// File: rtl/walk_fault_reg.sv
module walk_fault_reg #(
   parameter int VA_W = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            set_i,
   input  logic            clr_i,
   input  logic [VA_W-1:0] addr_i,
   output logic            flag_o,
   output logic [VA_W-1:0] addr_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_o <= 1'b0;
         addr_o <= '0;
      end else begin
         if (set_i) begin
            flag_o <= 1'b1;
            addr_o <= addr_i;
         end else if (clr_i) begin
            flag_o <= 1'b0;
         end
      end
   end

   // R12: the captured address moves only when this level records a fault
   p_addr_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !set_i |=> $stable(addr_o));
   // R11: a clear without a simultaneous fault leaves the flag low
   p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i && !set_i |=> !flag_o);
endmodule

// File: rtl/tbl_walker.sv
module tbl_walker
   import walk_pkg::*;
#(
   parameter int VA_W     = 32,
   parameter int DIR_W    = 12,
   parameter int PT_W     = 8,
   parameter int OFF_W    = 12,
   parameter int PT_ALIGN = 10,
   parameter int ACI_LSB  = 4,
   parameter int ACI_W    = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [VA_W-1:0]  dir_base,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [VA_W-1:0]  req_iova,
   output logic             rsp_valid,
   output logic             rsp_err,
   output logic [VA_W-1:0]  rsp_pa,
   output logic [ACI_W-1:0] rsp_aci,
   output logic             mem_req,
   output logic [VA_W-1:0]  mem_addr,
   input  logic             mem_ack,
   input  logic [VA_W-1:0]  mem_rdata,
   input  logic [1:0]       fault_clr,
   output logic             flt_dir,
   output logic             flt_pg,
   output logic [VA_W-1:0]  flt_dir_addr,
   output logic [VA_W-1:0]  flt_pg_addr
);
   localparam int ENT_B        = 2;
   localparam int DIR_LSB      = VA_W - DIR_W;
   localparam int PT_LSB       = OFF_W;
   localparam int DIR_BASE_LSB = DIR_W + ENT_B;
   localparam int PT_HI_W      = VA_W - PT_ALIGN;
   localparam int PG_HI_W      = VA_W - OFF_W;

   if (DIR_W + PT_W + OFF_W != VA_W) begin : g_bad_split
      $error("tbl_walker: address split does not cover the address");
   end
   if (PT_ALIGN != PT_W + ENT_B) begin : g_bad_align
      $error("tbl_walker: page-table alignment must equal table size");
   end

   walk_state_e          st_q;
   logic [VA_W-1:0]      va_q;
   logic [PT_HI_W-1:0]   pt_hi_q;
   logic [PG_HI_W-1:0]   pg_hi_q;
   logic [ACI_W-1:0]     aci_q;

   logic                 dir_ok, pg_ok;
   logic [PT_HI_W-1:0]   dir_ptr;
   logic [PG_HI_W-1:0]   pg_ptr;
   logic [ACI_W-1:0]     dir_aci_unused, pg_aci;
   logic [VA_W-1:0]      dir_ea, pg_ea;
   logic                 unused_base;

   walk_entry_decode #(
      .ENTRY_W(VA_W), .PTR_LSB(PT_ALIGN), .ACI_LSB(ACI_LSB), .ACI_W(ACI_W), .DIR_KIND(1'b1)
   ) u_dir_dec (
      .entry(mem_rdata), .ok(dir_ok), .ptr_hi(dir_ptr), .aci(dir_aci_unused)
   );

   walk_entry_decode #(
      .ENTRY_W(VA_W), .PTR_LSB(OFF_W), .ACI_LSB(ACI_LSB), .ACI_W(ACI_W), .DIR_KIND(1'b0)
   ) u_pg_dec (
      .entry(mem_rdata), .ok(pg_ok), .ptr_hi(pg_ptr), .aci(pg_aci)
   );

   assign unused_base = ^dir_base[DIR_BASE_LSB-1:0];
   assign dir_ea = {dir_base[VA_W-1:DIR_BASE_LSB], va_q[VA_W-1:DIR_LSB], {ENT_B{1'b0}}};
   assign pg_ea  = {pt_hi_q, va_q[DIR_LSB-1:PT_LSB], {ENT_B{1'b0}}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= W_IDLE;
         va_q    <= '0;
         pt_hi_q <= '0;
         pg_hi_q <= '0;
         aci_q   <= '0;
      end else begin
         case (st_q)
            W_IDLE: if (req_valid) begin
               va_q <= req_iova;
               st_q <= W_DIR;
            end
            W_DIR: if (mem_ack) begin
               if (dir_ok) begin
                  pt_hi_q <= dir_ptr;
                  st_q    <= W_PG;
               end else begin
                  st_q    <= W_FAULT;
               end
            end
            W_PG: if (mem_ack) begin
               if (pg_ok) begin
                  pg_hi_q <= pg_ptr;
                  aci_q   <= pg_aci;
                  st_q    <= W_DONE;
               end else begin
                  st_q    <= W_FAULT;
               end
            end
            default: st_q <= W_IDLE;
         endcase
      end
   end

   assign req_ready = (st_q == W_IDLE);
   assign mem_req   = (st_q == W_DIR) || (st_q == W_PG);
   assign mem_addr  = (st_q == W_PG) ? pg_ea : dir_ea;
   assign rsp_valid = (st_q == W_DONE) || (st_q == W_FAULT);
   assign rsp_err   = (st_q == W_FAULT);
   assign rsp_pa    = (st_q == W_DONE) ? {pg_hi_q, va_q[OFF_W-1:0]} : '0;
   assign rsp_aci   = (st_q == W_DONE) ? aci_q : '0;

   logic [N_LEVELS-1:0] flt_set, flt_flag;
   logic [VA_W-1:0]     flt_addr [N_LEVELS];

   assign flt_set[LVL_DIR] = (st_q == W_DIR) && mem_ack && !dir_ok;
   assign flt_set[LVL_PG]  = (st_q == W_PG)  && mem_ack && !pg_ok;

   for (genvar g = 0; g < N_LEVELS; g++) begin : g_flt
      walk_fault_reg #(.VA_W(VA_W)) u_reg (
         .clk(clk), .rst_n(rst_n),
         .set_i(flt_set[g]), .clr_i(fault_clr[g]), .addr_i(va_q),
         .flag_o(flt_flag[g]), .addr_o(flt_addr[g])
      );
   end

   assign flt_dir      = flt_flag[LVL_DIR];
   assign flt_pg       = flt_flag[LVL_PG];
   assign flt_dir_addr = flt_addr[LVL_DIR];
   assign flt_pg_addr  = flt_addr[LVL_PG];

   // R9: a pending read keeps its request and address until acknowledged
   p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req && $stable(mem_addr));
   // R2, R3: entry reads are word aligned
   p_word_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> mem_addr[ENT_B-1:0] == '0);
   // R10: a response lasts one cycle and is followed by an idle walker
   p_one_rsp_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid && req_ready);
   // R10: accepting a request drops ready on the next cycle
   p_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready && req_valid |=> !req_ready && mem_req);
   // R7, R8: an error response carries no translation
   p_err_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_err |-> rsp_pa == '0 && rsp_aci == '0);
   // R7: the directory flag rises only together with an error response
   p_dir_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flt_dir) |-> rsp_valid && rsp_err);
   // R8: the page flag rises only together with an error response
   p_pg_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flt_pg) |-> rsp_valid && rsp_err);
endmodule

// File: tb/tbl_walker_tb.sv
module tbl_walker_tb;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [31:0] dir_base;
   logic        req_valid;
   logic        req_ready;
   logic [31:0] req_iova;
   logic        rsp_valid, rsp_err;
   logic [31:0] rsp_pa;
   logic [3:0]  rsp_aci;
   logic        mem_req;
   logic [31:0] mem_addr;
   logic        mem_ack;
   logic [31:0] mem_rdata;
   logic [1:0]  fault_clr;
   logic        flt_dir, flt_pg;
   logic [31:0] flt_dir_addr, flt_pg_addr;

   int checks = 0;
   int errors = 0;
   int wait_n = 0;
   int n_rd   = 0;
   int stab_bad = 0;
   logic [31:0] rd_log [4];
   logic [31:0] hold_addr;
   logic [31:0] mem [logic [31:0]];

   always #4 clk = ~clk;

   tbl_walker u_dut (
      .clk(clk), .rst_n(rst_n), .dir_base(dir_base),
      .req_valid(req_valid), .req_ready(req_ready), .req_iova(req_iova),
      .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_pa(rsp_pa), .rsp_aci(rsp_aci),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .fault_clr(fault_clr), .flt_dir(flt_dir), .flt_pg(flt_pg),
      .flt_dir_addr(flt_dir_addr), .flt_pg_addr(flt_pg_addr)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] dir_ea(input logic [31:0] base, input logic [31:0] va);
      return {base[31:14], va[31:20], 2'b00};
   endfunction
   function automatic logic [31:0] pg_ea(input logic [31:0] dte, input logic [31:0] va);
      return {dte[31:10], va[19:12], 2'b00};
   endfunction

   // memory model: answers a pending read after wait_n wait cycles
   initial begin
      mem_ack = 1'b0;
      mem_rdata = '0;
      hold_addr = '0;
      begin
         int cnt;
         cnt = 0;
         forever begin
            @(negedge clk);
            if (mem_ack) begin
               mem_ack = 1'b0;
               cnt = 0;
            end else if (mem_req) begin
               if (cnt == 0) hold_addr = mem_addr;
               else if (mem_addr !== hold_addr) stab_bad++;
               if (cnt == wait_n) begin
                  mem_ack = 1'b1;
                  mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
                  if (n_rd < 4) rd_log[n_rd] = mem_addr;
                  n_rd++;
               end else begin
                  cnt++;
               end
            end
         end
      end
   end

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual %08h expected %08h", 32'h1, 32'h0);
      finish_run();
   end

   task automatic do_walk(input logic [31:0] va, output logic err, output logic [31:0] pa,
                          output logic [3:0] aci, output int reads);
      int busy_bad;
      int guard;
      busy_bad = 0;
      guard = 0;
      n_rd = 0;
      @(negedge clk);
      chk(req_ready === 1'b1, "R10 idle before request", {31'b0, req_ready}, 32'h1);
      req_valid = 1'b1;
      req_iova  = va;
      @(negedge clk);
      req_valid = 1'b0;
      req_iova  = 32'hDEAD_BEEF;
      while (!rsp_valid && guard < 500) begin
         if (req_ready) busy_bad++;
         @(negedge clk);
         guard++;
      end
      chk(busy_bad == 0, "R10 ready low while busy", busy_bad, 0);
      err = rsp_err;
      pa = rsp_pa;
      aci = rsp_aci;
      reads = n_rd;
      @(negedge clk);
      chk(!rsp_valid && req_ready, "R10 single-cycle response", {30'b0, rsp_valid, req_ready}, 32'h1);
   endtask

   task automatic t_reset();
      chk(req_ready === 1'b1, "R1 req_ready", {31'b0, req_ready}, 1);
      chk(rsp_valid === 1'b0 && mem_req === 1'b0, "R1 idle outputs", {30'b0, rsp_valid, mem_req}, 0);
      chk(flt_dir === 1'b0 && flt_pg === 1'b0, "R1 flags", {30'b0, flt_dir, flt_pg}, 0);
      chk(flt_dir_addr === 32'h0, "R1 dir error address", flt_dir_addr, 0);
      chk(flt_pg_addr === 32'h0, "R1 page error address", flt_pg_addr, 0);
   endtask

   task automatic map_entry(input logic [31:0] base, input logic [31:0] va,
                            input logic [31:0] dte, input logic [31:0] pte);
      mem[dir_ea(base, va)] = dte;
      mem[pg_ea(dte, va)]   = pte;
   endtask

   task automatic t_basic();
      logic err; logic [31:0] pa; logic [3:0] aci; int reads;
      logic [31:0] va, dte, pte;
      mem.delete();
      wait_n = 0;
      dir_base = 32'h8000_0000;
      va  = 32'h1234_5678;
      dte = 32'h0004_0401;
      pte = 32'hABCD_E032;
      map_entry(dir_base, va, dte, pte);
      do_walk(va, err, pa, aci, reads);
      chk(reads == 2, "R3 two reads", reads, 2);
      chk(rd_log[0] === dir_ea(dir_base, va), "R2 directory address", rd_log[0], dir_ea(dir_base, va));
      chk(rd_log[1] === pg_ea(dte, va), "R3 page address", rd_log[1], pg_ea(dte, va));
      chk(err === 1'b0, "R6 no error", {31'b0, err}, 0);
      chk(pa === 32'hABCD_E678, "R6 physical address", pa, 32'hABCD_E678);
      chk(aci === 4'h3, "R6 authority index", {28'b0, aci}, 3);
   endtask

   task automatic t_waits();
      logic err; logic [31:0] pa; logic [3:0] aci; int reads;
      logic [31:0] va, dte, pte;
      mem.delete();
      wait_n = 5;
      stab_bad = 0;
      dir_base = 32'h0010_0000;
      va  = 32'hFFF0_1ABC;
      dte = 32'h7FFF_FC01;
      pte = 32'h0000_10F2;
      map_entry(dir_base, va, dte, pte);
      do_walk(va, err, pa, aci, reads);
      chk(stab_bad == 0, "R9 address stable over wait cycles", stab_bad, 0);
      chk(rd_log[1] === pg_ea(dte, va), "R3 page address, top entry", rd_log[1], pg_ea(dte, va));
      chk(err === 1'b0 && pa === 32'h0000_1ABC, "R9 result after waits", pa, 32'h0000_1ABC);
      chk(aci === 4'hF, "R6 authority index all ones", {28'b0, aci}, 32'hF);
      wait_n = 0;
   endtask

   task automatic t_reserved();
      logic err; logic [31:0] pa; logic [3:0] aci; int reads;
      logic [31:0] va, dte, pte;
      mem.delete();
      wait_n = 1;
      dir_base = 32'h4000_3FFC;
      va  = 32'h0030_2004;
      dte = 32'h0000_83FD;
      pte = 32'h5555_5F5F;
      map_entry(dir_base, va, dte, pte);
      do_walk(va, err, pa, aci, reads);
      chk(rd_log[0] === {18'h10000, 12'h003, 2'b00}, "R2 base low bits ignored", rd_log[0], 32'h4000_000C);
      chk(rd_log[1] === 32'h0000_8008, "R4 reserved directory bits ignored", rd_log[1], 32'h0000_8008);
      chk(err === 1'b0 && pa === 32'h5555_5004, "R5 reserved page bits ignored", pa, 32'h5555_5004);
      chk(aci === 4'h5, "R5 authority index with reserved bits set", {28'b0, aci}, 5);
      wait_n = 0;
   endtask

   task automatic t_dir_fault();
      logic err; logic [31:0] pa; logic [3:0] aci; int reads;
      logic [31:0] va;
      logic [1:0] enc [3];
      enc[0] = 2'b00; enc[1] = 2'b10; enc[2] = 2'b11;
      mem.delete();
      dir_base = 32'h8000_0000;
      for (int i = 0; i < 3; i++) begin
         va = 32'h5000_0123 + (i << 20);
         mem[dir_ea(dir_base, va)] = {22'h0001F, 8'hFF, enc[i]};
         do_walk(va, err, pa, aci, reads);
         chk(reads == 1, "R7 single read on directory fault", reads, 1);
         chk(err === 1'b1, "R4 non-01 encoding faults", {31'b0, err}, 1);
         chk(pa === 32'h0 && aci === 4'h0, "R7 error response carries zero", pa, 0);
         chk(flt_dir === 1'b1 && flt_pg === 1'b0, "R7 directory flag", {30'b0, flt_dir, flt_pg}, 32'h2);
         chk(flt_dir_addr === va, "R7 directory error address", flt_dir_addr, va);
      end
   endtask

   task automatic t_pg_fault();
      logic err; logic [31:0] pa; logic [3:0] aci; int reads;
      logic [31:0] va, dte;
      dte = 32'h0002_0001;
      va  = 32'h6007_8FFF;
      mem[dir_ea(dir_base, va)] = dte;
      mem[pg_ea(dte, va)] = 32'hFFFF_FFFD;
      do_walk(va, err, pa, aci, reads);
      chk(reads == 2, "R8 two reads on page fault", reads, 2);
      chk(err === 1'b1 && pa === 32'h0 && aci === 4'h0, "R8 error response", pa, 0);
      chk(flt_pg === 1'b1, "R8 page flag", {31'b0, flt_pg}, 1);
      chk(flt_pg_addr === va, "R8 page error address", flt_pg_addr, va);
      chk(flt_dir_addr === 32'h5020_0123, "R12 directory address kept on page fault", flt_dir_addr, 32'h5020_0123);
   endtask

   task automatic t_clear();
      logic err; logic [31:0] pa; logic [3:0] aci; int reads;
      logic [31:0] va, dte, pg_keep, dir_keep;
      pg_keep  = flt_pg_addr;
      dir_keep = flt_dir_addr;
      @(negedge clk);
      fault_clr = 2'b01;
      @(negedge clk);
      fault_clr = 2'b00;
      chk(flt_dir === 1'b0 && flt_pg === 1'b1, "R11 clear directory flag only", {30'b0, flt_dir, flt_pg}, 1);
      chk(flt_dir_addr === dir_keep, "R12 address kept after clear", flt_dir_addr, dir_keep);
      va  = 32'h7778_9ABC;
      dte = 32'h0030_0C01;
      map_entry(dir_base, va, dte, 32'h9999_9002);
      do_walk(va, err, pa, aci, reads);
      chk(err === 1'b0 && pa === 32'h9999_9ABC, "R6 walk after faults", pa, 32'h9999_9ABC);
      chk(flt_pg_addr === pg_keep && flt_dir_addr === dir_keep, "R12 addresses kept over success", flt_pg_addr, pg_keep);
      @(negedge clk);
      fault_clr = 2'b10;
      @(negedge clk);
      fault_clr = 2'b00;
      chk(flt_pg === 1'b0 && flt_dir === 1'b0, "R11 clear page flag", {30'b0, flt_dir, flt_pg}, 0);
   endtask

   initial begin
      rst_n = 1'b0;
      dir_base = '0;
      req_valid = 1'b0;
      req_iova = '0;
      fault_clr = 2'b00;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_waits();
      t_reserved();
      t_dir_fault();
      t_pg_fault();
      t_clear();
      repeat (2) @(negedge clk);
      finish_run();
   end
endmodule